// File: doc/BRIEF.md
# Banked Memory Map Decoder with DMA Lockout

This block sits between an 8-bit CPU and the storage arrays of a handheld console. It turns each 16-bit CPU address into a one-hot region select and an offset inside that region. For work RAM, the offset already includes the bank. It also produces the read and write strobes for the selected storage. The storage arrays, the cartridge mapper's registers and the video renderer are outside the block. The block only decides who is addressed, whether the access is allowed, and what byte the CPU sees.

Two conditions stop an access from reaching storage:

- **Video mode:** sprite-attribute memory is reachable only in the two quiet video modes.
- **Sprite DMA:** while a sprite DMA runs, the CPU loses the sprite-attribute memory. It also loses one bus range, picked from a per-model table indexed by the top three bits of the DMA source address.

A blocked or unbacked read gives 0xFF, and a blocked write is dropped. The byte the CPU reads is held in a register one cycle after the read request.

Top module: `mmap_decode_top`

## Requirements
- R1: `regionSel` is one-hot and decodes combinationally as follows:
  - bit 0: 0x0000-0x3FFF, fixed ROM.
  - bit 1: 0x4000-0x7FFF, banked ROM.
  - bit 2: 0x8000-0x9FFF, video RAM.
  - bit 3: 0xA000-0xBFFF, cartridge RAM.
  - bit 4: 0xC000-0xCFFF and its mirror 0xE000-0xEFFF, work RAM low.
  - bit 5: 0xD000-0xDFFF and its mirror 0xF000-0xFDFF, work RAM banked.
  - bit 6: 0xFE00-0xFE9F, sprite attributes.
  - bit 7: 0xFEA0-0xFEFF, hole.
  - bit 8: 0xFF00-0xFF7F, I/O.
  - bit 9: 0xFF80-0xFFFE, high RAM.
  - bit 10: 0xFFFF, interrupt enable.
- R2: `localOffset` gives the position inside the region:
  - ROM regions: address bits 13:0.
  - Video RAM and cartridge RAM: bits 12:0.
  - Work RAM low: bits 11:0.
  - Work RAM banked: `{wramBank, address[11:0]}`.
  - Sprite attributes: bits 7:0.
  - I/O and high RAM: bits 6:0.
  - Hole and interrupt enable: zero.
- R3: The work-RAM bank register loads `bankWrData[2:0]` on `bankWrEn`, and a loaded value of 0 becomes 1. After reset it holds 1.
- R4: Sprite-attribute memory is accessible only when `videoMode` is 0 or 1. In modes 2 and 3 a read returns 0xFF and a write raises no strobe.
- R5: A read of the hole returns 0xFF, and a write there raises no strobe.
- R6: Cartridge RAM accesses are routed by priority:
  - With `rtcEn`, a read returns `rtcRdata` and a write raises `rtcWrEn`.
  - Otherwise, with `ramEn`, the access goes to memory (`memRdEn`/`memWrEn`).
  - Otherwise a read returns 0xFF and a write is dropped.
- R7: A write to 0x0000-0x7FFF raises `mapperWr` and never `memWrEn`.
- R8: While `dmaActive` is set, 0xFE00-0xFE9F is blocked regardless of the model.
- R9: With `colorModel`=0 and `dmaActive` set, the blocked range depends on `dmaSrcHi`:
  - `dmaSrcHi`=4: 0x8000-0x9FFF is blocked.
  - any other `dmaSrcHi`: 0xA000-0xFDFF is blocked.
- R10: With `colorModel`=1 and `dmaActive` set, the blocked range depends on `dmaSrcHi`:
  - `dmaSrcHi`=4: 0x8000-0x9FFF is blocked.
  - `dmaSrcHi`=6: 0xC000-0xFDFF is blocked.
  - any other `dmaSrcHi`: 0xA000-0xBFFF is blocked.
- R11: A blocked read returns 0xFF and a blocked access raises none of `memRdEn`, `memWrEn`, `rtcWrEn`, `mapperWr`.
- R12: `cpuRdata` updates on the clock edge that samples `cpuRd`, holds its value when `cpuRd` is low, and resets to 0xFF. Otherwise the byte is `memRdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuAddr | input | 16 | CPU address |
| cpuRd | input | 1 | CPU read request |
| cpuWr | input | 1 | CPU write request |
| videoMode | input | 2 | Current video mode |
| rtcEn | input | 1 | Clock registers mapped over cartridge RAM |
| ramEn | input | 1 | Cartridge RAM enabled |
| dmaActive | input | 1 | Sprite DMA in progress |
| dmaSrcHi | input | 3 | DMA source address bits 15:13 |
| colorModel | input | 1 | 1 selects the colour-model lockout table |
| bankWrEn | input | 1 | Load the work-RAM bank register |
| bankWrData | input | 8 | Value for the bank register |
| memRdata | input | 8 | Byte returned by the selected storage |
| rtcRdata | input | 8 | Byte of the active clock register |
| regionSel | output | 11 | One-hot region select |
| localOffset | output | 15 | Offset inside the region |
| wramBank | output | 3 | Current work-RAM bank |
| memRdEn | output | 1 | Storage read strobe |
| memWrEn | output | 1 | Storage write strobe |
| rtcWrEn | output | 1 | Clock register write strobe |
| mapperWr | output | 1 | Write routed to the mapper |
| cpuRdata | output | 8 | Registered read data |

## Verification
A DMA lockout and a video-mode gate can both apply to the same sprite-attribute access. Likewise, a lockout can fall on cartridge RAM while the clock-register path is enabled. The sweep produces these overlaps by varying `videoMode`, `rtcEn` and `ramEn` with the address index while DMA is active, for each of the eight source indices and both models. The bench judges each access by the rule that blocking wins over every other route: the read byte must be 0xFF and no strobe may rise. When the gate and the lockout agree, the bench also checks that the result is the same either way.

// File: rtl/mmap_pkg.sv
package mmap_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;
  localparam int BANK_W = 3;
  localparam int OFS_W  = BANK_W + 12;
  localparam int NREG   = 11;

  typedef enum logic [3:0] {
    RG_ROM0 = 4'd0, RG_ROMX = 4'd1, RG_VRAM = 4'd2, RG_XRAM = 4'd3,
    RG_WLO  = 4'd4, RG_WHI  = 4'd5, RG_OAM  = 4'd6, RG_HOLE = 4'd7,
    RG_IO   = 4'd8, RG_HRAM = 4'd9, RG_IE   = 4'd10
  } region_e;

  typedef struct packed {
    logic [NREG-1:0] sel;
    logic            openBus;
    logic            rtcPath;
    logic            memRd;
    logic            memWr;
    logic            rtcWr;
    logic            mapWr;
  } ctrlStrobes_t;
endpackage

// File: rtl/mmap_ctrl.sv
module mmap_ctrl
  import mmap_pkg::*;
(
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              cpuRd,
  input  logic              cpuWr,
  input  logic [1:0]        videoMode,
  input  logic              rtcEn,
  input  logic              ramEn,
  input  logic              dmaActive,
  input  logic [2:0]        dmaSrcHi,
  input  logic              colorModel,
  output ctrlStrobes_t      strobes
);
  region_e region;
  logic [NREG-1:0] sel;
  logic [ADDR_W-1:0] lockLo, lockHi;
  logic inOam, tableHit, blocked, oamGate, xramNone, romArea;

  always_comb begin
    case (cpuAddr[15:12])
      4'h0, 4'h1, 4'h2, 4'h3: region = RG_ROM0;
      4'h4, 4'h5, 4'h6, 4'h7: region = RG_ROMX;
      4'h8, 4'h9:             region = RG_VRAM;
      4'hA, 4'hB:             region = RG_XRAM;
      4'hC, 4'hE:             region = RG_WLO;
      4'hD:                   region = RG_WHI;
      default: begin
        if (cpuAddr < 16'hFE00)      region = RG_WHI;
        else if (cpuAddr < 16'hFEA0) region = RG_OAM;
        else if (cpuAddr < 16'hFF00) region = RG_HOLE;
        else if (cpuAddr < 16'hFF80) region = RG_IO;
        else if (cpuAddr < 16'hFFFF) region = RG_HRAM;
        else                         region = RG_IE;
      end
    endcase
    sel = '0;
    sel[region] = 1'b1;
  end

  // Lockout range lookup: the source index picks the bus the DMA occupies.
  always_comb begin
    if (dmaSrcHi == 3'd4) begin
      lockLo = 16'h8000; lockHi = 16'hA000;
    end else if (!colorModel) begin
      lockLo = 16'hA000; lockHi = 16'hFE00;
    end else if (dmaSrcHi == 3'd6) begin
      lockLo = 16'hC000; lockHi = 16'hFE00;
    end else begin
      lockLo = 16'hA000; lockHi = 16'hC000;
    end
  end

  assign inOam    = sel[RG_OAM];
  assign tableHit = (cpuAddr >= lockLo) && (cpuAddr < lockHi);
  assign blocked  = dmaActive && (inOam || tableHit);
  assign oamGate  = sel[RG_OAM] && videoMode[1];
  assign xramNone = sel[RG_XRAM] && !rtcEn && !ramEn;
  assign romArea  = sel[RG_ROM0] || sel[RG_ROMX];

  always_comb begin
    strobes.sel     = sel;
    strobes.openBus = blocked || oamGate || sel[RG_HOLE] || xramNone;
    strobes.rtcPath = sel[RG_XRAM] && rtcEn && !blocked;
    strobes.memRd   = cpuRd && !strobes.openBus && !strobes.rtcPath;
    strobes.rtcWr   = cpuWr && strobes.rtcPath;
    strobes.mapWr   = cpuWr && romArea && !blocked;
    strobes.memWr   = cpuWr && !blocked && !oamGate && !sel[RG_HOLE] && !romArea
                      && !(sel[RG_XRAM] && (rtcEn || !ramEn));
  end
endmodule

// File: rtl/mmap_datapath.sv
module mmap_datapath
  import mmap_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              cpuRd,
  input  ctrlStrobes_t      strobes,
  input  logic              bankWrEn,
  input  logic [DATA_W-1:0] bankWrData,
  input  logic [DATA_W-1:0] memRdata,
  input  logic [DATA_W-1:0] rtcRdata,
  output logic [OFS_W-1:0]  localOffset,
  output logic [BANK_W-1:0] wramBank,
  output logic [DATA_W-1:0] cpuRdata
);
  logic [BANK_W-1:0] bankNext;
  logic [DATA_W-1:0] rdNext;

  assign bankNext = (bankWrData[BANK_W-1:0] == '0) ? BANK_W'(1) : bankWrData[BANK_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN)         wramBank <= BANK_W'(1);
    else if (bankWrEn) wramBank <= bankNext;
  end

  always_comb begin
    localOffset = '0;
    unique case (1'b1)
      strobes.sel[RG_ROM0], strobes.sel[RG_ROMX]: localOffset = OFS_W'(cpuAddr[13:0]);
      strobes.sel[RG_VRAM], strobes.sel[RG_XRAM]: localOffset = OFS_W'(cpuAddr[12:0]);
      strobes.sel[RG_WLO]:  localOffset = OFS_W'(cpuAddr[11:0]);
      strobes.sel[RG_WHI]:  localOffset = {wramBank, cpuAddr[11:0]};
      strobes.sel[RG_OAM]:  localOffset = OFS_W'(cpuAddr[7:0]);
      strobes.sel[RG_IO], strobes.sel[RG_HRAM]: localOffset = OFS_W'(cpuAddr[6:0]);
      default: localOffset = '0;
    endcase
  end

  assign rdNext = strobes.openBus ? '1 : (strobes.rtcPath ? rtcRdata : memRdata);

  always_ff @(posedge clk) begin
    if (!rstN)      cpuRdata <= '1;
    else if (cpuRd) cpuRdata <= rdNext;
  end
endmodule

// File: rtl/mmap_decode_top.sv
module mmap_decode_top
  import mmap_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              cpuRd,
  input  logic              cpuWr,
  input  logic [1:0]        videoMode,
  input  logic              rtcEn,
  input  logic              ramEn,
  input  logic              dmaActive,
  input  logic [2:0]        dmaSrcHi,
  input  logic              colorModel,
  input  logic              bankWrEn,
  input  logic [DATA_W-1:0] bankWrData,
  input  logic [DATA_W-1:0] memRdata,
  input  logic [DATA_W-1:0] rtcRdata,
  output logic [NREG-1:0]   regionSel,
  output logic [OFS_W-1:0]  localOffset,
  output logic [BANK_W-1:0] wramBank,
  output logic              memRdEn,
  output logic              memWrEn,
  output logic              rtcWrEn,
  output logic              mapperWr,
  output logic [DATA_W-1:0] cpuRdata
);
  ctrlStrobes_t strobes;

  mmap_ctrl uCtrl (
    .cpuAddr(cpuAddr), .cpuRd(cpuRd), .cpuWr(cpuWr), .videoMode(videoMode),
    .rtcEn(rtcEn), .ramEn(ramEn), .dmaActive(dmaActive), .dmaSrcHi(dmaSrcHi),
    .colorModel(colorModel), .strobes(strobes)
  );

  mmap_datapath uData (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuRd(cpuRd), .strobes(strobes),
    .bankWrEn(bankWrEn), .bankWrData(bankWrData), .memRdata(memRdata),
    .rtcRdata(rtcRdata), .localOffset(localOffset), .wramBank(wramBank),
    .cpuRdata(cpuRdata)
  );

  assign regionSel = strobes.sel;
  assign memRdEn   = strobes.memRd;
  assign memWrEn   = strobes.memWr;
  assign rtcWrEn   = strobes.rtcWr;
  assign mapperWr  = strobes.mapWr;
endmodule

// File: rtl/mmap_checker.sv
module mmap_checker
  import mmap_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] cpuAddr,
  input logic              cpuRd,
  input logic              cpuWr,
  input logic [1:0]        videoMode,
  input logic              dmaActive,
  input logic [NREG-1:0]   regionSel,
  input logic [BANK_W-1:0] wramBank,
  input logic              memWrEn,
  input logic              mapperWr,
  input logic [DATA_W-1:0] cpuRdata
);
  assert_onehot_region_R1: assert property (@(posedge clk) disable iff (!rstN)
    $countones(regionSel) == 1);

  assert_bank_nonzero_R3: assert property (@(posedge clk) disable iff (!rstN)
    wramBank != '0);

  assert_oam_gate_R4: assert property (@(posedge clk) disable iff (!rstN)
    (cpuWr && regionSel[RG_OAM] && videoMode[1]) |-> !memWrEn);

  assert_hole_open_R5: assert property (@(posedge clk) disable iff (!rstN)
    (cpuRd && regionSel[RG_HOLE]) |=> (cpuRdata == 8'hFF));

  assert_mapper_only_R7: assert property (@(posedge clk) disable iff (!rstN)
    (cpuWr && !cpuAddr[15]) |-> (mapperWr && !memWrEn));

  assert_dma_oam_R8: assert property (@(posedge clk) disable iff (!rstN)
    (dmaActive && regionSel[RG_OAM] && cpuRd) |=> (cpuRdata == 8'hFF));

  assert_hold_rdata_R12: assert property (@(posedge clk) disable iff (!rstN)
    !cpuRd |=> $stable(cpuRdata));
endmodule

bind mmap_decode_top mmap_checker uChk (
  .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuRd(cpuRd), .cpuWr(cpuWr),
  .videoMode(videoMode), .dmaActive(dmaActive), .regionSel(regionSel),
  .wramBank(wramBank), .memWrEn(memWrEn), .mapperWr(mapperWr), .cpuRdata(cpuRdata)
);

// File: tb/tb_mmap_decode_top.sv
`timescale 1ns/1ps
module tb_mmap_decode_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [15:0] cpuAddr = '0;
  logic cpuRd = 1'b0, cpuWr = 1'b0;
  logic [1:0] videoMode = '0;
  logic rtcEn = 1'b0, ramEn = 1'b0, dmaActive = 1'b0, colorModel = 1'b0;
  logic [2:0] dmaSrcHi = '0;
  logic bankWrEn = 1'b0;
  logic [7:0] bankWrData = '0;
  logic [7:0] memRdata, rtcRdata;
  logic [10:0] regionSel;
  logic [14:0] localOffset;
  logic [2:0] wramBank;
  logic memRdEn, memWrEn, rtcWrEn, mapperWr;
  logic [7:0] cpuRdata;

  int checks = 0, errors = 0;
  logic [2:0] expBank = 3'd1;
  bit finished = 0;

  always #2 clk = ~clk;
  assign memRdata = cpuAddr[7:0] ^ 8'h5A;
  assign rtcRdata = 8'hC3;

  mmap_decode_top dut (.*);

  function automatic int expRegion(input logic [15:0] a);
    if (a < 16'h4000) return 0;
    if (a < 16'h8000) return 1;
    if (a < 16'hA000) return 2;
    if (a < 16'hC000) return 3;
    if (a < 16'hD000) return 4;
    if (a < 16'hE000) return 5;
    if (a < 16'hF000) return 4;
    if (a < 16'hFE00) return 5;
    if (a < 16'hFEA0) return 6;
    if (a < 16'hFF00) return 7;
    if (a < 16'hFF80) return 8;
    if (a < 16'hFFFF) return 9;
    return 10;
  endfunction

  function automatic logic expBlocked(input logic [15:0] a);
    logic [15:0] lo, hi;
    if (!dmaActive) return 1'b0;
    if (a >= 16'hFE00 && a < 16'hFEA0) return 1'b1;
    if (dmaSrcHi == 4) begin lo = 16'h8000; hi = 16'hA000; end
    else if (!colorModel) begin lo = 16'hA000; hi = 16'hFE00; end
    else if (dmaSrcHi == 6) begin lo = 16'hC000; hi = 16'hFE00; end
    else begin lo = 16'hA000; hi = 16'hC000; end
    return (a >= lo) && (a < hi);
  endfunction

  function automatic logic [14:0] expOffset(input logic [15:0] a, input int r);
    case (r)
      0, 1: return {1'b0, a[13:0]};
      2, 3: return {2'b0, a[12:0]};
      4: return {3'b0, a[11:0]};
      5: return {expBank, a[11:0]};
      6: return {7'b0, a[7:0]};
      8, 9: return {8'b0, a[6:0]};
      default: return '0;
    endcase
  endfunction

  function automatic string tagFor(input logic [15:0] a, input int r, input logic blk);
    if (blk) begin
      if (r == 6) return "R8";
      return colorModel ? "R10" : "R9";
    end
    if (r == 6) return "R4";
    if (r == 7) return "R5";
    if (r == 3) return "R6";
    if (r <= 1 && a < 16'h8000) return "R7";
    return "R12";
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s addr=%h actual=%h expected=%h", req, what, cpuAddr, act, exp);
    end
  endtask

  task automatic writeBank(input logic [7:0] v);
    @(negedge clk);
    bankWrEn = 1'b1; bankWrData = v;
    @(negedge clk);
    bankWrEn = 1'b0;
    expBank = (v[2:0] == 0) ? 3'd1 : v[2:0];
    #1 check("R3", "wramBank", 32'(wramBank), 32'(expBank));
  endtask

  task automatic probe(input logic [15:0] a, input int idx);
    int r;
    logic blk, gate, xnone, open, rtcp;
    logic [7:0] expRd;
    string tg;
    @(negedge clk);
    cpuAddr = a; cpuRd = 1'b1; cpuWr = 1'b0;
    videoMode = idx[1:0]; rtcEn = idx[2]; ramEn = idx[3];
    #1;
    r = expRegion(a);
    blk = expBlocked(a);
    gate = (r == 6) && videoMode[1];
    xnone = (r == 3) && !rtcEn && !ramEn;
    open = blk || gate || (r == 7) || xnone;
    rtcp = (r == 3) && rtcEn && !blk;
    tg = tagFor(a, r, blk);
    check("R1", "regionSel", 32'(regionSel), 32'(11'b1 << r));
    check((r == 5) ? "R3" : "R2", "localOffset", 32'(localOffset), 32'(expOffset(a, r)));
    check(blk ? "R11" : tg, "memRdEn", 32'(memRdEn), 32'(!open && !rtcp));
    expRd = open ? 8'hFF : (rtcp ? 8'hC3 : (a[7:0] ^ 8'h5A));
    @(posedge clk); #1;
    check(blk ? "R11" : tg, "cpuRdata", 32'(cpuRdata), 32'(expRd));
    @(negedge clk);
    cpuRd = 1'b0; cpuWr = 1'b1;
    #1;
    check(blk ? "R11" : tg, "memWrEn", 32'(memWrEn),
          32'(!blk && !gate && r != 7 && r > 1 && !((r == 3) && (rtcEn || !ramEn))));
    check(blk ? "R11" : tg, "rtcWrEn", 32'(rtcWrEn), 32'(rtcp));
    check(blk ? "R11" : "R7", "mapperWr", 32'(mapperWr), 32'(r <= 1 && !blk));
    @(posedge clk); #1;
    check("R12", "cpuRdata hold", 32'(cpuRdata), 32'(expRd));
    cpuWr = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] edges [25] = '{16'h0000, 16'h3FFF, 16'h4000, 16'h7FFF, 16'h8000,
      16'h9FFF, 16'hA000, 16'hBFFF, 16'hC000, 16'hCFFF, 16'hD000, 16'hDFFF,
      16'hE000, 16'hEFFF, 16'hF000, 16'hFDFF, 16'hFE00, 16'hFE9F, 16'hFEA0,
      16'hFEFF, 16'hFF00, 16'hFF7F, 16'hFF80, 16'hFFFE, 16'hFFFF};
    int idx = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    #1;
    check("R12", "reset cpuRdata", 32'(cpuRdata), 32'hFF);
    check("R3", "reset wramBank", 32'(wramBank), 32'd1);
    writeBank(8'h00);
    writeBank(8'hFD);
    writeBank(8'h08);
    writeBank(8'h07);
    for (int m = 0; m < 2; m++) begin
      for (int cfg = 0; cfg < 9; cfg++) begin
        colorModel = m[0];
        dmaActive = (cfg < 8);
        dmaSrcHi = cfg[2:0];
        writeBank(8'(cfg * 3 + m));
        for (int k = 0; k < 256; k++) begin
          probe({k[7:0], k[7:0] ^ 8'h9F}, idx);
          idx++;
        end
        for (int e = 0; e < 25; e++) begin
          probe(edges[e], idx);
          idx++;
        end
      end
    end
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule